// File: doc/BRIEF.md
# Preamble Sampling Phase Search Engine

This block picks the ADC sampling phase for a receiver that samples at the symbol rate. Once packet detection reports a packet, the engine drives a phase-select code to the tunable sampling clock generator. It then measures the received energy of one repeated preamble symbol for each candidate phase. The energy metric is the sum of the squared I and Q sample magnitudes over the symbol. Carrier frequency offset only rotates the samples and leaves their magnitudes unchanged, so the search can start as soon as the packet is detected.

The search is a knockout over three rounds, with 8 candidates in the first round, then 4, then 2. In each round the surviving phases are measured again on fresh preamble symbols. The higher-energy half goes on to the next round. The complete search uses 8 + 4 + 2 = 14 preamble symbols. At the end the engine holds the winning phase code on its output and raises a done flag. If the preamble runs out early, the engine stops, reports the best phase it has so far and marks the result as incomplete.

Top module: `pss_phase_search`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `busy`, `done` and `incomplete` are 0 and `phase_sel` is 0.
- R2: In the first round `phase_sel` steps through 0, 1, ..., 7 in that order. Each code is held for exactly 128 samples that have `smp_valid` high. Cycles with `smp_valid` low do not count and leave `phase_sel` unchanged.
- R3: A candidate's metric is the exact sum of I*I + Q*Q over its 128 samples. I and Q are 6-bit two's complement values. The sum does not wrap, even with every sample at I = Q = -32 (metric 262144).
- R4: Rounds two and three measure only the survivors of the previous round, in ascending phase order, with one fresh symbol each. The survivors of a round are the 4 (then 2) candidates with the highest metrics measured in that round.
- R5: When two metrics are equal, the lower phase index ranks higher. This applies when survivors are chosen and when the winner is chosen.
- R6: In the cycle after the last valid sample of the 14th measured symbol, `done`=1, `busy`=0, `incomplete`=0 and `phase_sel` is the third-round candidate with the highest metric. These values hold until the next `pkt_start`.
- R7: If `pre_end` is high while a search is running and that cycle does not finish the last measurement, then in the next cycle `done`=1 and `incomplete`=1. `phase_sel` is then, in order of preference: the best fully measured candidate of the current round; if none, the previous round's winner; if neither exists, 0. A partly accumulated symbol is discarded.
- R8: `pkt_start` has no effect while `busy` is high. `pre_end` has no effect while `busy` is low.
- R9: `pkt_start` while the engine is idle or done starts a fresh search. In the next cycle `busy`=1, `done`=0, `incomplete`=0 and `phase_sel`=0, and earlier results are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Packet detected; starts a search when the engine is not busy |
| pre_end | input | 1 | Preamble is over; ends a running search early |
| smp_valid | input | 1 | Strobe marking a valid I/Q sample |
| smp_i | input | 6 | In-phase sample, two's complement |
| smp_q | input | 6 | Quadrature sample, two's complement |
| phase_sel | output | 3 | Phase code to the sampling clock generator: the candidate under measurement while busy, the result when done |
| busy | output | 1 | A search is running |
| done | output | 1 | The result on `phase_sel` is final |
| incomplete | output | 1 | The search ended early on `pre_end` (valid with `done`) |

## Verification
An error in the sample counter or the survivor mask shows at the port in the same symbol. The code on `phase_sel` moves after the wrong number of valid samples, or to a phase that should already have been eliminated. So the per-symbol checks of the phase schedule catch it within one preamble symbol. Errors in the accumulator or the ranking, such as a truncated width, a wrong tie rule or a stale metric, do not show until a round closes. They appear as a wrong survivor order in the next round or a wrong final code, at most 14 symbols after the start. Full-scale and single-LSB stimulus makes such errors change the outcome. The early-end path keeps separate state (best so far, partial-symbol discard), so it is exercised by cutting the preamble at the start, mid-symbol, on round boundaries and on the final sample.

// File: rtl/pss_pkg.sv
package pss_pkg;

    // Default configuration of the search engine
    localparam int PSS_IQ_W    = 6;    // bits per I or Q sample
    localparam int PSS_N_PHASE = 8;    // candidate sampling phases
    localparam int PSS_N_SAMP  = 128;  // samples per energy measurement

    // Engine control state
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DONE   = 2'd2
    } pss_state_e;

    // Status flags presented at the block edge
    typedef struct packed {
        logic busy;
        logic done;
        logic incomplete;
    } pss_flags_t;

    // Number of candidates that survive a given knockout round
    function automatic logic [31:0] keep_count(input int n_phase, input int round);
        return 32'(n_phase >> (round + 1));
    endfunction

endpackage

// File: rtl/pss_energy_acc.sv
module pss_energy_acc #(
    parameter int IQ_W   = 6,
    parameter int N_SAMP = 128,
    parameter int SQ_W   = 2 * IQ_W,
    parameter int ACC_W  = 2 * IQ_W + $clog2(N_SAMP)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   in_valid,
    input  logic signed [IQ_W-1:0] smp_i,
    input  logic signed [IQ_W-1:0] smp_q,
    output logic                   meas_done,
    output logic [ACC_W-1:0]       meas_energy
);
    localparam int CNT_W = (N_SAMP > 1) ? $clog2(N_SAMP) : 1;

    logic [CNT_W-1:0]       cnt_q;
    logic [ACC_W-1:0]       acc_q;
    logic signed [SQ_W-1:0] i_ext, q_ext, i_sq, q_sq;
    logic [SQ_W-1:0]        pwr;

    // Square each component at full width; the sum of two squares of
    // IQ_W-bit values always fits in 2*IQ_W unsigned bits.
    assign i_ext = SQ_W'(smp_i);
    assign q_ext = SQ_W'(smp_q);
    assign i_sq  = i_ext * i_ext;
    assign q_sq  = q_ext * q_ext;
    assign pwr   = SQ_W'($unsigned(i_sq)) + SQ_W'($unsigned(q_sq));

    assign meas_done   = in_valid && (cnt_q == CNT_W'(N_SAMP - 1));
    assign meas_energy = acc_q + ACC_W'(pwr);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (in_valid) begin
            if (meas_done) begin
                cnt_q <= '0;
                acc_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
                acc_q <= meas_energy;
            end
        end
    end

endmodule

// File: rtl/pss_picker.sv
module pss_picker #(
    parameter int N_PHASE = 8,
    parameter int PH_W    = $clog2(N_PHASE)
) (
    input  logic [N_PHASE-1:0] mask,
    input  logic [PH_W:0]      from,
    output logic [PH_W-1:0]    idx,
    output logic               found
);
    // Lowest set position of mask at or above 'from'
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N_PHASE - 1; k >= 0; k--) begin
            if (mask[k] && (k >= int'(from))) begin
                found = 1'b1;
                idx   = PH_W'(k);
            end
        end
    end

endmodule

// File: rtl/pss_ranker.sv
module pss_ranker #(
    parameter int N_PHASE = 8,
    parameter int ACC_W   = 19,
    parameter int PH_W    = $clog2(N_PHASE)
) (
    input  logic [N_PHASE-1:0][ACC_W-1:0] energy,
    input  logic [N_PHASE-1:0]            alive,
    input  logic [PH_W:0]                 keep_n,
    output logic [N_PHASE-1:0]            keep
);
    // Each live candidate counts the live rivals that beat it: a rival
    // beats it with a larger metric, or an equal metric and lower index.
    for (genvar g = 0; g < N_PHASE; g++) begin : g_rank
        logic [PH_W:0] beaten_by;

        always_comb begin
            beaten_by = '0;
            for (int j = 0; j < N_PHASE; j++) begin
                if (alive[j] && (j != g) &&
                    ((energy[j] > energy[g]) ||
                     ((energy[j] == energy[g]) && (j < g)))) begin
                    beaten_by = beaten_by + (PH_W + 1)'(1);
                end
            end
        end

        assign keep[g] = alive[g] && (beaten_by < keep_n);
    end

endmodule

// File: rtl/pss_phase_search.sv
module pss_phase_search
    import pss_pkg::*;
#(
    parameter int IQ_W    = PSS_IQ_W,
    parameter int N_PHASE = PSS_N_PHASE,
    parameter int N_SAMP  = PSS_N_SAMP
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pkt_start,
    input  logic                          pre_end,
    input  logic                          smp_valid,
    input  logic signed [IQ_W-1:0]        smp_i,
    input  logic signed [IQ_W-1:0]        smp_q,
    output logic [$clog2(N_PHASE)-1:0]    phase_sel,
    output logic                          busy,
    output logic                          done,
    output logic                          incomplete
);
    localparam int PH_W    = $clog2(N_PHASE);
    localparam int SQ_W    = 2 * IQ_W;
    localparam int ACC_W   = SQ_W + $clog2(N_SAMP);
    localparam int N_ROUND = PH_W;
    localparam int RND_W   = (N_ROUND > 1) ? $clog2(N_ROUND) : 1;

    pss_state_e                    state_q;
    logic [PH_W-1:0]               cur_q;
    logic [N_PHASE-1:0]            alive_q;
    logic [RND_W-1:0]              round_q;
    logic                          have_q;
    logic [PH_W-1:0]               leader_q;
    logic [ACC_W-1:0]              best_q;
    logic                          inc_q;
    logic [N_PHASE-1:0][ACC_W-1:0] energy_q;

    logic                          in_search;
    logic                          meas_done;
    logic [ACC_W-1:0]              meas_energy;
    logic [N_PHASE-1:0][ACC_W-1:0] energy_view;
    logic [N_PHASE-1:0]            keep_mask;
    logic [PH_W:0]                 keep_n;
    logic [PH_W-1:0]               nxt_idx, first_idx;
    logic                          nxt_found, first_found;
    logic                          better, final_meas;
    pss_flags_t                    flags;

    assign in_search = (state_q == ST_SEARCH);

    // Energy of the symbol currently being captured
    pss_energy_acc #(
        .IQ_W   (IQ_W),
        .N_SAMP (N_SAMP),
        .SQ_W   (SQ_W),
        .ACC_W  (ACC_W)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .clear       (!in_search),
        .in_valid    (smp_valid && in_search),
        .smp_i       (smp_i),
        .smp_q       (smp_q),
        .meas_done   (meas_done),
        .meas_energy (meas_energy)
    );

    // Metrics of this round including the one finishing now
    always_comb begin
        energy_view = energy_q;
        if (meas_done) energy_view[cur_q] = meas_energy;
    end

    assign keep_n = (PH_W + 1)'(keep_count(N_PHASE, int'(round_q)));

    pss_ranker #(
        .N_PHASE (N_PHASE),
        .ACC_W   (ACC_W),
        .PH_W    (PH_W)
    ) u_rank (
        .energy (energy_view),
        .alive  (alive_q),
        .keep_n (keep_n),
        .keep   (keep_mask)
    );

    // Next survivor of this round after the current one
    pss_picker #(
        .N_PHASE (N_PHASE),
        .PH_W    (PH_W)
    ) u_next (
        .mask  (alive_q),
        .from  ({1'b0, cur_q} + (PH_W + 1)'(1)),
        .idx   (nxt_idx),
        .found (nxt_found)
    );

    // First survivor of the coming round
    pss_picker #(
        .N_PHASE (N_PHASE),
        .PH_W    (PH_W)
    ) u_first (
        .mask  (keep_mask),
        .from  ('0),
        .idx   (first_idx),
        .found (first_found)
    );

    // Candidates are visited in ascending order, so a strict comparison
    // keeps the lower index on a tie.
    assign better     = !have_q || (meas_energy > best_q);
    assign final_meas = meas_done && !nxt_found &&
                        (round_q == RND_W'(N_ROUND - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            alive_q  <= '0;
            round_q  <= '0;
            have_q   <= 1'b0;
            leader_q <= '0;
            best_q   <= '0;
            inc_q    <= 1'b0;
            energy_q <= '0;
        end else begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (meas_done) begin
                        energy_q[cur_q] <= meas_energy;
                        have_q          <= 1'b1;
                        if (better) begin
                            leader_q <= cur_q;
                            best_q   <= meas_energy;
                        end
                    end
                    if (final_meas) begin
                        state_q <= ST_DONE;
                        inc_q   <= 1'b0;
                    end else if (pre_end) begin
                        state_q <= ST_DONE;
                        inc_q   <= 1'b1;
                    end else if (meas_done) begin
                        if (nxt_found) begin
                            cur_q <= nxt_idx;
                        end else begin
                            alive_q <= keep_mask;
                            round_q <= round_q + RND_W'(1);
                            cur_q   <= first_found ? first_idx : cur_q;
                            have_q  <= 1'b0;
                        end
                    end
                end
                default: begin
                    if (pkt_start) begin
                        state_q  <= ST_SEARCH;
                        cur_q    <= '0;
                        alive_q  <= '1;
                        round_q  <= '0;
                        have_q   <= 1'b0;
                        leader_q <= '0;
                        best_q   <= '0;
                        inc_q    <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign flags.busy       = in_search;
    assign flags.done       = (state_q == ST_DONE);
    assign flags.incomplete = (state_q == ST_DONE) && inc_q;

    assign busy       = flags.busy;
    assign done       = flags.done;
    assign incomplete = flags.incomplete;
    assign phase_sel  = flags.busy ? cur_q :
                        (flags.done ? leader_q : '0);

endmodule

// File: rtl/pss_phase_search_chk.sv
module pss_phase_search_chk #(
    parameter int N_PHASE = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       pkt_start,
    input logic                       pre_end,
    input logic                       smp_valid,
    input logic [$clog2(N_PHASE)-1:0] phase_sel,
    input logic                       busy,
    input logic                       done,
    input logic                       incomplete,
    input logic [N_PHASE-1:0]         alive
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !incomplete && (phase_sel == '0)));

    // R6
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R7
    incomplete_flag_chk: assert property (@(posedge clk) disable iff (rst)
        incomplete |-> done);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !pkt_start) |=> (done && $stable(phase_sel) && $stable(incomplete)));

    // R2
    idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !smp_valid && !pre_end) |=> (busy && $stable(phase_sel)));

    // R4
    survivor_sel_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> alive[phase_sel]);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && pkt_start && !pre_end && !smp_valid) |=> busy);

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && pkt_start) |=> (busy && !done && (phase_sel == '0)));

endmodule

bind pss_phase_search pss_phase_search_chk #(
    .N_PHASE (N_PHASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pkt_start  (pkt_start),
    .pre_end    (pre_end),
    .smp_valid  (smp_valid),
    .phase_sel  (phase_sel),
    .busy       (busy),
    .done       (done),
    .incomplete (incomplete),
    .alive      (alive_q)
);

// File: tb/pss_phase_search_tb.sv
module pss_phase_search_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IQ_W       = 6;
    localparam int NPH        = 8;
    localparam int NS         = 128;
    localparam int PH_W       = 3;
    localparam int WD_LIMIT   = 150000;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   pkt_start = 1'b0;
    logic                   pre_end = 1'b0;
    logic                   smp_valid = 1'b0;
    logic signed [IQ_W-1:0] smp_i = '0;
    logic signed [IQ_W-1:0] smp_q = '0;
    logic [PH_W-1:0]        phase_sel;
    logic                   busy, done, incomplete;

    int checks = 0;
    int fails  = 0;
    bit all_done = 1'b0;

    // Reference state kept by the bench
    bit [NPH-1:0] m_alive;
    int m_round, m_cur, m_cnt, m_lead, m_best;
    bit m_have, m_fin;
    int m_en [NPH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pss_phase_search #(
        .IQ_W    (IQ_W),
        .N_PHASE (NPH),
        .N_SAMP  (NS)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pkt_start  (pkt_start),
        .pre_end    (pre_end),
        .smp_valid  (smp_valid),
        .smp_i      (smp_i),
        .smp_q      (smp_q),
        .phase_sel  (phase_sel),
        .busy       (busy),
        .done       (done),
        .incomplete (incomplete)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Magnitude used for a candidate in a round of a given scenario
    function automatic int mag(input int t, input int r, input int p);
        if (t == 0)  return 20;
        if (t <= 8)  return ((p * (2 * t + 1) + r * (t + 2) + t) % 8) * 4 + 1;
        if (t == 9)  return (r == 0) ? (p / 2) * 6 : ((r == 1) ? ((7 - p) / 2) * 6 : 10);
        if (t == 10) return 31;
        return 25;
    endfunction

    function automatic int si(input int t, input int r, input int p, input int k);
        int v;
        if (t == 10 && p == 5) return -32;
        v = mag(t, r, p);
        if (t == 11 && p == 6 && k == 100) v = v + 1;
        return (k % 2 == 1) ? -v : v;
    endfunction

    function automatic int sq(input int t, input int r, input int p, input int k);
        int v;
        if (t == 10 && p == 5) return -32;
        v = mag(t, r, p);
        return (k % 4 < 2) ? v : -v;
    endfunction

    function automatic int energy(input int t, input int r, input int p);
        int s = 0;
        for (int k = 0; k < NS; k++) begin
            s += si(t, r, p, k) * si(t, r, p, k) + sq(t, r, p, k) * sq(t, r, p, k);
        end
        return s;
    endfunction

    // Advance the reference by one valid sample
    task automatic model_sample(input int t);
        int e, nxt, rank, kn;
        bit [NPH-1:0] keep;
        m_cnt++;
        if (m_cnt == NS) begin
            e = energy(t, m_round, m_cur);
            m_en[m_cur] = e;
            if (!m_have || e > m_best) begin
                m_lead = m_cur;
                m_best = e;
            end
            m_have = 1'b1;
            m_cnt  = 0;
            nxt    = -1;
            for (int k = NPH - 1; k > m_cur; k--) if (m_alive[k]) nxt = k;
            if (nxt >= 0) begin
                m_cur = nxt;
            end else if (m_round == 2) begin
                m_fin = 1'b1;
            end else begin
                kn   = NPH >> (m_round + 1);
                keep = '0;
                for (int a = 0; a < NPH; a++) begin
                    rank = 0;
                    for (int b = 0; b < NPH; b++) begin
                        if (m_alive[a] && m_alive[b] && b != a &&
                            (m_en[b] > m_en[a] || (m_en[b] == m_en[a] && b < a))) rank++;
                    end
                    if (m_alive[a] && rank < kn) keep[a] = 1'b1;
                end
                m_alive = keep;
                m_round++;
                m_have = 1'b0;
                for (int k = NPH - 1; k >= 0; k--) if (keep[k]) m_cur = k;
            end
        end
    endtask

    // One search. abort_at < 0: no early end. abort_with: pre_end rides on that sample.
    task automatic run(input int t, input bit gaps, input int abort_at, input bit abort_with,
                       input bit start_mid, input int exp_win, input string tag);
        int fed = 0;
        int cyc = 0;
        bit pend_r8 = 1'b0;
        m_alive = '1; m_round = 0; m_cur = 0; m_cnt = 0;
        m_lead = 0; m_best = 0; m_have = 1'b0; m_fin = 1'b0;

        @(negedge clk);
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        // R9 fresh start
        chk(busy && !done && !incomplete && phase_sel == 0, "R9 restart state", int'(phase_sel), 0);

        while (!m_fin && !(abort_at >= 0 && !abort_with && fed == abort_at)) begin
            @(negedge clk);
            cyc++;
            smp_valid = 1'b0;
            pre_end   = 1'b0;
            pkt_start = 1'b0;
            if (pend_r8) begin
                // R8 start while busy ignored
                chk(busy && int'(phase_sel) == m_cur, "R8 start ignored while busy", int'(phase_sel), m_cur);
                pend_r8 = 1'b0;
            end
            if (gaps && (cyc % 3 == 0)) continue;
            if (m_cnt == 0) begin
                if (m_round == 0)
                    chk(busy && int'(phase_sel) == m_cur, "R2 first-round order", int'(phase_sel), m_cur);
                else
                    chk(busy && int'(phase_sel) == m_cur, "R4 survivor order", int'(phase_sel), m_cur);
            end
            smp_valid = 1'b1;
            smp_i = IQ_W'(si(t, m_round, m_cur, m_cnt));
            smp_q = IQ_W'(sq(t, m_round, m_cur, m_cnt));
            if (start_mid && fed == 500) begin
                pkt_start = 1'b1;
                pend_r8   = 1'b1;
            end
            if (abort_with && fed + 1 == abort_at) pre_end = 1'b1;
            fed++;
            model_sample(t);
        end

        if (m_fin) begin
            @(negedge clk);
            smp_valid = 1'b0;
            pre_end   = 1'b0;
            pkt_start = 1'b0;
            chk(done && !busy, "R6 done after last symbol", int'(done), 1);
            chk(!incomplete, "R6 complete flag", int'(incomplete), 0);
            chk(int'(phase_sel) == m_lead, "R6 winner code", int'(phase_sel), m_lead);
        end else begin
            @(negedge clk);
            smp_valid = 1'b0;
            pkt_start = 1'b0;
            pre_end   = 1'b1;
            @(negedge clk);
            pre_end = 1'b0;
            chk(done && !busy, "R7 early end done", int'(done), 1);
            chk(incomplete, "R7 incomplete flag", int'(incomplete), 1);
            chk(int'(phase_sel) == m_lead, "R7 best so far", int'(phase_sel), m_lead);
        end
        if (exp_win >= 0) chk(int'(phase_sel) == exp_win, tag, int'(phase_sel), exp_win);

        // R8 pre_end ignored once done
        @(negedge clk);
        pre_end = 1'b1;
        @(negedge clk);
        pre_end = 1'b0;
        chk(done && !busy && int'(phase_sel) == m_lead && incomplete == !m_fin,
            "R8 pre_end ignored when done", int'(phase_sel), m_lead);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !incomplete && phase_sel == 0, "R1 in reset", int'(phase_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !incomplete && phase_sel == 0, "R1 after reset", int'(phase_sel), 0);
        pre_end = 1'b1;
        @(negedge clk);
        pre_end = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !incomplete, "R8 pre_end ignored when idle", int'(done), 0);

        run(0, 1'b0, -1, 1'b0, 1'b0, 0, "R5 all-equal tie");
        for (int t = 1; t <= 8; t++) run(t, 1'b0, -1, 1'b0, 1'b0, -1, "");
        run(9,  1'b0, -1, 1'b0, 1'b0, 4, "R5 paired ties");
        run(10, 1'b0, -1, 1'b0, 1'b0, 5, "R3 full-scale sum");
        run(11, 1'b0, -1, 1'b0, 1'b0, 6, "R3 single-LSB margin");
        run(3,  1'b1, -1, 1'b0, 1'b1, -1, "");
        run(1,  1'b0, 0, 1'b0, 1'b0, 0, "R7 end before any symbol");
        run(2,  1'b0, 3 * NS + 50, 1'b0, 1'b0, -1, "");
        run(4,  1'b0, 8 * NS, 1'b0, 1'b0, -1, "");
        run(5,  1'b0, 10 * NS + 10, 1'b0, 1'b0, -1, "");
        run(6,  1'b0, 14 * NS, 1'b1, 1'b0, -1, "");

        all_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < WD_LIMIT; n++) @(posedge clk);
        if (!all_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule